// File: doc/BRIEF.md
# PRBS Error and Multiframe Time-Base Counters

This block measures the quality of a received pseudo-random test pattern. An external pattern comparator pulses a one-cycle error strobe for every bit error it finds, and the block adds each strobe to an error tally. A second counter advances on a one-cycle strobe at each received CRC-4 multiframe boundary. It provides the time base, so the error tally can be turned into an error rate.

Both counters sit behind a small register port. Software can read them and load them. A write to the error tally also resets the time base to zero. One write therefore starts a new measurement window: software presets the error tally, then reads both counters after a while. When the error tally wraps from its top value to zero, a sticky overflow flag is set. That flag drives an interrupt line through a mask bit. The multiframe counter wraps silently.

The register port has four addresses. Address 0 is the error tally. Address 1 is the multiframe counter. Address 2 is the overflow status (read-only, bit 0). Address 3 is the interrupt mask (bit 0). Read data is combinational from `addr_i`.

Top module: `prbs_meas_counters`

## Requirements
- R1: After reset, both counters, the overflow status and the mask read as 0, and `irq_o` is low.
- R2: Each cycle with `err_strobe_i` high and no write to address 0 raises the error tally (address 0) by one, modulo 256.
- R3: Each cycle with `mf_strobe_i` high and no write to address 0 or 1 raises the multiframe counter (address 1) by one.
- R4: A write to address 0 loads `wdata_i` into the error tally and sets the multiframe counter to 0. This holds even if `mf_strobe_i` is high in the same cycle.
- R5: A write to address 1 loads `wdata_i` into the multiframe counter, and a multiframe strobe in the same cycle is lost. The error tally is not changed.
- R6: If an error strobe and a write to address 0 fall in the same cycle, the tally takes the written value.
- R7: An increment of the error tally from 0xFF to 0x00 sets status bit 0 (address 2). The bit stays set until a read of address 2 (`rd_en_i` high), which returns 1 and then clears it. If a new wrap falls in the same cycle as that read, the bit stays set.
- R8: The multiframe counter wraps from 0xFF to 0x00 and does not touch the overflow status.
- R9: Mask bit 0 (address 3) is writable and reads back. `irq_o` is high exactly when both the status bit and the mask bit are 1.
- R10: Writes to address 2 have no effect on the overflow status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_strobe_i | input | 1 | One-cycle pulse per detected pattern bit error |
| mf_strobe_i | input | 1 | One-cycle pulse per received multiframe boundary |
| wr_en_i | input | 1 | Register write enable |
| rd_en_i | input | 1 | Register read enable (clears status on address 2) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from `addr_i` |
| irq_o | output | 1 | Masked overflow interrupt |

## Verification
The assertions assume that the strobes and the register controls are synchronous single-cycle levels that are known after reset. They also assume that `wr_en_i` and `rd_en_i` carry an address that is held for that cycle. The bench changes every input half a period away from the rising edge and holds it for one full cycle. It reads registers only by driving `rd_en_i`, so the one read-clear side effect happens exactly where the expected-value model applies it. A sweep presets all 256 error-tally values and applies one strobe to each. It covers every increment and the single wrap point against arithmetic expectations.

// File: rtl/prbs_meas_pkg.sv
package prbs_meas_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ERR  = 2'd0,
        SEL_MF   = 2'd1,
        SEL_STAT = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ovf;
        logic mask;
    } ctl_state_t;
endpackage

// File: rtl/prbs_reg_decode.sv
module prbs_reg_decode
    import prbs_meas_pkg::*;
(
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              wr_err_o,
    output logic              wr_mf_o,
    output logic              wr_mask_o,
    output logic              rd_stat_o
);
    always_comb begin
        wr_err_o  = wr_en_i && (addr_i == SEL_ERR);
        wr_mf_o   = wr_en_i && (addr_i == SEL_MF);
        wr_mask_o = wr_en_i && (addr_i == SEL_MASK);
        rd_stat_o = rd_en_i && (addr_i == SEL_STAT);
    end
endmodule

// File: rtl/prbs_wrap_counter.sv
module prbs_wrap_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    // priority: load, then clear, then increment
    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d  = cnt_q + 1'b1;
            wrap_o = (cnt_q == TOP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/prbs_meas_counters.sv
module prbs_meas_counters
    import prbs_meas_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_strobe_i,
    input  logic              mf_strobe_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic              irq_o
);
    logic wr_err, wr_mf, wr_mask, rd_stat;
    logic [CNT_W-1:0] err_cnt, mf_cnt;
    logic err_wrap, mf_wrap;
    logic ovf_flag, mask_flag;
    ctl_state_t st_d, st_q;

    prbs_reg_decode u_dec (
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .wr_err_o (wr_err),
        .wr_mf_o  (wr_mf),
        .wr_mask_o(wr_mask),
        .rd_stat_o(rd_stat)
    );

    prbs_wrap_counter #(.W(CNT_W)) u_err_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (err_strobe_i),
        .load_i    (wr_err),
        .load_val_i(wdata_i),
        .clr_i     (1'b0),
        .cnt_o     (err_cnt),
        .wrap_o    (err_wrap)
    );

    // a write to the error tally restarts the time base
    prbs_wrap_counter #(.W(CNT_W)) u_mf_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (mf_strobe_i),
        .load_i    (wr_mf),
        .load_val_i(wdata_i),
        .clr_i     (wr_err),
        .cnt_o     (mf_cnt),
        .wrap_o    (mf_wrap)
    );

    always_comb begin
        st_d = st_q;
        if (rd_stat)  st_d.ovf  = 1'b0;
        if (err_wrap) st_d.ovf  = 1'b1;
        if (wr_mask)  st_d.mask = wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_flag  = st_q.ovf;
    assign mask_flag = st_q.mask;

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            SEL_ERR:  rdata_o = err_cnt;
            SEL_MF:   rdata_o = mf_cnt;
            SEL_STAT: rdata_o[0] = ovf_flag;
            SEL_MASK: rdata_o[0] = mask_flag;
            default:  rdata_o = '0;
        endcase
    end

    assign irq_o = ovf_flag & mask_flag;

    logic unused_mf_wrap;
    assign unused_mf_wrap = mf_wrap;
endmodule

// File: rtl/prbs_meas_counters_chk.sv
module prbs_meas_counters_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_strobe_i,
    input logic             mf_strobe_i,
    input logic             wr_en_i,
    input logic             rd_en_i,
    input logic [1:0]       addr_i,
    input logic [CNT_W-1:0] wdata_i,
    input logic [CNT_W-1:0] err_cnt,
    input logic [CNT_W-1:0] mf_cnt,
    input logic             ovf
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // R2
    err_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe_i && !(wr_en_i && addr_i == 2'd0) && err_cnt != TOP)
        |=> err_cnt == CNT_W'($past(err_cnt) + 1'b1));

    // R4
    err_write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 2'd0) |=> (mf_cnt == '0 && err_cnt == $past(wdata_i)));

    // R5
    mf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 2'd1) |=> mf_cnt == $past(wdata_i));

    // R7
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($past(err_cnt) == TOP && $past(err_strobe_i)));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(rd_en_i && addr_i == 2'd2)) |=> ovf);

    // R8
    mf_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf && !err_strobe_i) |=> !ovf);
endmodule

bind prbs_meas_counters prbs_meas_counters_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_strobe_i(err_strobe_i),
    .mf_strobe_i (mf_strobe_i),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .err_cnt     (err_cnt),
    .mf_cnt      (mf_cnt),
    .ovf         (ovf_flag)
);

// File: tb/prbs_meas_counters_tb.sv
module prbs_meas_counters_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       err_strobe_i = 1'b0;
    logic       mf_strobe_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [1:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prbs_meas_counters u_dut (
        .clk(clk), .rst_n(rst_n), .err_strobe_i(err_strobe_i), .mf_strobe_i(mf_strobe_i),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, applied at the falling edge
    task automatic cyc(input bit we, input bit re, input logic [1:0] a,
                       input logic [7:0] d, input bit es, input bit ms);
        @(negedge clk);
        wr_en_i = we; rd_en_i = re; addr_i = a; wdata_i = d;
        err_strobe_i = es; mf_strobe_i = ms;
        @(posedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        wr_en_i = 0; rd_en_i = 1; addr_i = a; err_strobe_i = 0; mf_strobe_i = 0;
        #1 v = rdata_o;
        @(posedge clk);
    endtask

    task automatic irq_now(output bit v);
        @(negedge clk);
        wr_en_i = 0; rd_en_i = 0; err_strobe_i = 0; mf_strobe_i = 0;
        #1 v = irq_o;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit i;
        #12 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reg", v, 0);
        end
        irq_now(i); check("R1 irq", i, 0);

        // R9 mask write and readback
        cyc(1, 0, 2'd3, 8'h01, 0, 0);
        rd(2'd3, v); check("R9 mask", v, 1);
        irq_now(i); check("R9 irq no status", i, 0);

        // R2 strobe counts
        cyc(1, 0, 2'd0, 8'h00, 0, 0);
        for (int n = 1; n <= 12; n++) begin
            cyc(0, 0, 2'd1, 8'h00, 1, 0);
            rd(2'd0, v); check("R2 count", v, n);
        end

        // R3 multiframe counts
        cyc(1, 0, 2'd1, 8'h00, 0, 0);
        for (int n = 0; n < 7; n++) cyc(0, 0, 2'd2, 8'h00, 0, 1);
        rd(2'd1, v); check("R3 mf", v, 7);

        // R4 write restarts time base, even with same-cycle mf strobe
        cyc(1, 0, 2'd0, 8'h33, 0, 1);
        rd(2'd0, v); check("R4 err load", v, 8'h33);
        rd(2'd1, v); check("R4 mf cleared", v, 0);

        // R5 mf load wins over strobe, error tally untouched
        cyc(1, 0, 2'd1, 8'h10, 0, 1);
        rd(2'd1, v); check("R5 mf load", v, 8'h10);
        rd(2'd0, v); check("R5 err kept", v, 8'h33);

        // R6 write beats error strobe
        cyc(1, 0, 2'd0, 8'h40, 1, 0);
        rd(2'd0, v); check("R6 write wins", v, 8'h40);

        // R7 wrap sets sticky status; read clears; R9 irq follows mask
        cyc(1, 0, 2'd0, 8'hFD, 0, 0);
        for (int n = 0; n < 3; n++) cyc(0, 0, 2'd1, 8'h00, 1, 0);
        irq_now(i); check("R9 irq set", i, 1);
        rd(2'd0, v); check("R7 wrapped", v, 0);
        // R10 write to status ignored while set
        cyc(1, 0, 2'd2, 8'h00, 0, 0);
        cyc(0, 0, 2'd0, 8'h00, 0, 0);
        cyc(0, 0, 2'd0, 8'h00, 0, 0);
        cyc(1, 0, 2'd3, 8'h00, 0, 0);
        irq_now(i); check("R9 irq masked", i, 0);
        rd(2'd2, v); check("R7 status sticky", v, 1);
        rd(2'd2, v); check("R7 status cleared", v, 0);
        // R10 write to status while clear
        cyc(1, 0, 2'd2, 8'hFF, 0, 0);
        rd(2'd2, v); check("R10 status", v, 0);

        // R7 wrap in same cycle as status read keeps bit set
        cyc(1, 0, 2'd0, 8'hFF, 0, 0);
        cyc(0, 1, 2'd2, 8'h00, 1, 0);
        rd(2'd2, v); check("R7 set beats clear", v, 1);
        rd(2'd2, v); check("R7 cleared after", v, 0);

        // R8 mf wrap raises nothing
        cyc(1, 0, 2'd1, 8'hFE, 0, 0);
        for (int n = 0; n < 3; n++) cyc(0, 0, 2'd0, 8'h00, 0, 1);
        rd(2'd1, v); check("R8 mf wrap", v, 1);
        rd(2'd2, v); check("R8 no status", v, 0);

        // R2/R7 sweep over every preset value
        for (int s = 0; s < 256; s++) begin
            cyc(1, 0, 2'd0, 8'(s), 0, 0);
            cyc(0, 0, 2'd1, 8'h00, 1, 0);
            rd(2'd0, v); check("R2 sweep", v, (s + 1) % 256);
            rd(2'd2, v); check("R7 sweep", v, (s == 255) ? 1 : 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule